// File: doc/BRIEF.md
# Block Store Address and Register Sequencer

This block drives the memory side of a store-multiple operation in a load/store processor. When it sees a start pulse it captures a register-select mask, a base address, one of four addressing modes, a writeback flag and the address of the store instruction. It then steps through the selected registers one per cycle. For each register it places a register-file read index on its output and issues one word write to memory. At the end it reports the base value that the caller should write back.

Two registers need special values. Register 15, the program counter, is stored as the instruction address plus 12. The base register, when it is in the list, is stored as its original value if it is the first register transferred. If it comes later and writeback is on, the already-moved value is stored instead. The register file, the memory and the decoder stay outside the block. Memory writes use a valid/ready handshake, and a write is held until memory accepts it.

Top module: `blkstore_seq`

## Requirements
- R1: Selected registers are written in ascending register-number order, each write carrying the register-file data at the index shown on `rf_idx_o`, and the lowest-numbered register always lands at the lowest address in every mode.
- R2: Mode 2'b00 (increment, address then step): the k-th write goes to base + 4k.
- R3: Mode 2'b01 (step then address): the k-th write goes to base + 4 + 4k.
- R4: Mode 2'b10 (decrement, address then step): the highest selected register goes to base, and each lower one goes to the word below it; with n registers, the k-th write goes to base - 4(n-1-k).
- R5: Mode 2'b11 (decrement, step then address): the k-th write of n goes to base - 4(n-k), so the first goes to base - 4n and the last to base - 4.
- R6: At completion, `wb_value_o` is base + 4n for modes with bit 1 clear and base - 4n for modes with bit 1 set when the writeback flag was set, and equals base when it was clear; `wb_en_o` repeats the captured writeback flag.
- R7: A write for register 15 carries the instruction address plus 12 instead of register-file data.
- R8: When the base register (index `base_idx_i`, below 15) is the first register transferred, its original base value is written.
- R9: When the base register is selected but not first, the written value is the final base if writeback is set and the original base if it is clear.
- R10: While `mem_valid_o` is high and `mem_ready_i` is low, the write's address and data do not change and valid stays high.
- R11: With ready held high, writes come on consecutive cycles, and `done_o` is a one-cycle pulse raised in the cycle after the last accepted write; counted in cycles after the start cycle, it appears in cycle n+2, and no write is pending during it.
- R12: An all-zero mask gives `done_o` in the cycle after start, with no memory write and with `wb_value_o` equal to the base.
- R13: A start pulse that arrives while a sequence is in progress is ignored; it neither changes the running sequence nor starts another one afterwards.
- R14: After reset, `mem_valid_o`, `done_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a sequence (taken only when idle) |
| reg_mask_i | input | NREG | Register-select mask, bit i selects register i |
| base_i | input | AW | Base address |
| base_idx_i | input | log2(NREG) | Register number holding the base |
| mode_i | input | 2 | Bit 1: decrement; bit 0: step before addressing |
| wb_i | input | 1 | Writeback of the moved base requested |
| instr_addr_i | input | AW | Address of the store instruction |
| rf_idx_o | output | log2(NREG) | Register-file read index for the next write |
| rf_data_i | input | DW | Register-file read data for `rf_idx_o` (same cycle) |
| mem_valid_o | output | 1 | Memory write pending |
| mem_addr_o | output | AW | Memory write address |
| mem_data_o | output | DW | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the pending write |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Captured writeback flag, valid with `done_o` |
| wb_value_o | output | AW | Base value to write back, valid with `done_o` |

## Verification
A wrong remaining-mask or address register shows up at the memory port on the next accepted write. The write lands at the wrong address, its data belongs to a different register, or there are too many or too few writes before `done_o`. A wrong end-of-sequence decision shows up as a `done_o` pulse in the wrong cycle, or as a `wb_value_o` off by a multiple of four. These are checked one cycle after they occur. A stale first-transfer flag corrupts only the base register's stored word, so it is caught by cases that place the base both first and later in the list.

// File: rtl/blkstore_pkg.sv
package blkstore_pkg;
  typedef enum logic [1:0] {
    AM_INC_AFTER  = 2'b00,
    AM_INC_BEFORE = 2'b01,
    AM_DEC_AFTER  = 2'b10,
    AM_DEC_BEFORE = 2'b11
  } addr_mode_e;

  localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/blkstore_popcnt.sv
module blkstore_popcnt #(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits_i,
  output logic [CW-1:0] count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < N; i++) begin
      count_o = count_o + CW'(bits_i[i]);
    end
  end
endmodule

// File: rtl/blkstore_lowpick.sv
module blkstore_lowpick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask_i,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  onehot_o,
  output logic          any_o
);
  // lowest set bit wins: scan from the top so the last hit is the lowest
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |mask_i;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_oh
      assign onehot_o[g] = any_o && (idx_o == IW'(g));
    end
  endgenerate
endmodule

// File: rtl/blkstore_addrgen.sv
module blkstore_addrgen
  import blkstore_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 5
) (
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] count_i,
  input  logic [1:0]    mode_i,
  output logic [AW-1:0] first_addr_o,
  output logic [AW-1:0] end_base_o
);
  localparam logic [AW-1:0] WSTEP = AW'(WORD_BYTES);

  logic [AW-1:0] span;
  addr_mode_e    mode;

  assign span = AW'(count_i) * WSTEP;
  assign mode = addr_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      AM_INC_AFTER:  first_addr_o = base_i;
      AM_INC_BEFORE: first_addr_o = base_i + WSTEP;
      AM_DEC_AFTER:  first_addr_o = base_i - span + WSTEP;
      AM_DEC_BEFORE: first_addr_o = base_i - span;
      default:       first_addr_o = base_i;
    endcase
  end

  assign end_base_o = mode_i[1] ? (base_i - span) : (base_i + span);
endmodule

// File: rtl/blkstore_seq.sv
module blkstore_seq
  import blkstore_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int PC_OFS = 12,
  localparam int IW    = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [NREG-1:0] reg_mask_i,
  input  logic [AW-1:0] base_i,
  input  logic [IW-1:0] base_idx_i,
  input  logic [1:0]    mode_i,
  input  logic          wb_i,
  input  logic [AW-1:0] instr_addr_i,
  output logic [IW-1:0] rf_idx_o,
  input  logic [DW-1:0] rf_data_i,
  output logic          mem_valid_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  input  logic          mem_ready_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_value_o
);
  localparam int CW = $clog2(NREG + 1);
  localparam logic [IW-1:0] PC_IDX = IW'(NREG - 1);
  localparam logic [AW-1:0] WSTEP  = AW'(WORD_BYTES);

  // captured operation
  logic [NREG-1:0] rem_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   orig_q;
  logic [AW-1:0]   fin_q;
  logic [AW-1:0]   pcv_q;
  logic [IW-1:0]   bidx_q;
  logic            wbf_q;
  logic            first_q;
  logic            busy_q;

  // registered outputs
  logic            mv_q;
  logic [AW-1:0]   ma_q;
  logic [DW-1:0]   md_q;
  logic            done_q;
  logic            wen_q;
  logic [AW-1:0]   wval_q;

  logic [CW-1:0]   sel_cnt;
  logic [AW-1:0]   first_addr;
  logic [AW-1:0]   end_base;
  logic [IW-1:0]   pick_idx;
  logic [NREG-1:0] pick_oh;
  logic            pick_any;
  logic            slot_free;
  logic [DW-1:0]   store_val;

  blkstore_popcnt #(.N(NREG), .CW(CW)) u_cnt (
    .bits_i  (reg_mask_i),
    .count_o (sel_cnt)
  );

  blkstore_addrgen #(.AW(AW), .CW(CW)) u_agen (
    .base_i       (base_i),
    .count_i      (sel_cnt),
    .mode_i       (mode_i),
    .first_addr_o (first_addr),
    .end_base_o   (end_base)
  );

  blkstore_lowpick #(.N(NREG), .IW(IW)) u_pick (
    .mask_i   (rem_q),
    .idx_o    (pick_idx),
    .onehot_o (pick_oh),
    .any_o    (pick_any)
  );

  assign slot_free = !mv_q || mem_ready_i;

  // value written for the register picked this cycle
  always_comb begin
    if (pick_idx == PC_IDX) begin
      store_val = DW'(pcv_q);
    end else if (pick_idx == bidx_q) begin
      store_val = first_q ? DW'(orig_q) : DW'(fin_q);
    end else begin
      store_val = rf_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      addr_q  <= '0;
      orig_q  <= '0;
      fin_q   <= '0;
      pcv_q   <= '0;
      bidx_q  <= '0;
      wbf_q   <= 1'b0;
      first_q <= 1'b0;
      busy_q  <= 1'b0;
      mv_q    <= 1'b0;
      ma_q    <= '0;
      md_q    <= '0;
      done_q  <= 1'b0;
      wen_q   <= 1'b0;
      wval_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start_i) begin
        rem_q   <= reg_mask_i;
        addr_q  <= first_addr;
        orig_q  <= base_i;
        fin_q   <= wb_i ? end_base : base_i;
        pcv_q   <= instr_addr_i + AW'(PC_OFS);
        bidx_q  <= base_idx_i;
        wbf_q   <= wb_i;
        first_q <= 1'b1;
        if (reg_mask_i == '0) begin
          done_q <= 1'b1;
          wen_q  <= wb_i;
          wval_q <= base_i;
        end else begin
          busy_q <= 1'b1;
        end
      end else if (busy_q && slot_free) begin
        if (pick_any) begin
          mv_q    <= 1'b1;
          ma_q    <= addr_q;
          md_q    <= store_val;
          rem_q   <= rem_q & ~pick_oh;
          addr_q  <= addr_q + WSTEP;
          first_q <= 1'b0;
        end else begin
          mv_q   <= 1'b0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
          wen_q  <= wbf_q;
          wval_q <= fin_q;
        end
      end
    end
  end

  assign rf_idx_o    = pick_idx;
  assign mem_valid_o = mv_q;
  assign mem_addr_o  = ma_q;
  assign mem_data_o  = md_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign wb_en_o     = wen_q;
  assign wb_value_o  = wval_q;
endmodule

// File: rtl/blkstore_seq_chk.sv
module blkstore_seq_chk #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            start_i,
  input logic [NREG-1:0] reg_mask_i,
  input logic            mem_valid_o,
  input logic [AW-1:0]   mem_addr_o,
  input logic [DW-1:0]   mem_data_o,
  input logic            mem_ready_i,
  input logic            busy_o,
  input logic            done_o
);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R11
  done_idle_port_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!mem_valid_o && !busy_o));

  // R1
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid_o && mem_ready_i) |=>
      (!mem_valid_o || (mem_addr_o == $past(mem_addr_o) + AW'(4))));

  // R12
  empty_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && (reg_mask_i == '0)) |=> (done_o && !mem_valid_o));

  // R13
  write_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid_o |-> busy_o);
endmodule

bind blkstore_seq blkstore_seq_chk #(.NREG(NREG), .AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .reg_mask_i  (reg_mask_i),
  .mem_valid_o (mem_valid_o),
  .mem_addr_o  (mem_addr_o),
  .mem_data_o  (mem_data_o),
  .mem_ready_i (mem_ready_i),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/blkstore_seq_tb.sv
module blkstore_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] reg_mask_i = '0;
  logic [31:0] base_i = '0;
  logic [3:0]  base_idx_i = '0;
  logic [1:0]  mode_i = '0;
  logic        wb_i = 1'b0;
  logic [31:0] instr_addr_i = '0;
  logic [3:0]  rf_idx_o;
  logic [31:0] rf_data_i;
  logic        mem_valid_o;
  logic [31:0] mem_addr_o;
  logic [31:0] mem_data_o;
  logic        mem_ready = 1'b0;
  logic        busy_o, done_o, wb_en_o;
  logic [31:0] wb_value_o;

  logic [31:0] rf [16];
  assign rf_data_i = rf[rf_idx_o];

  always #2.5 clk = ~clk;

  blkstore_seq u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .reg_mask_i(reg_mask_i),
    .base_i(base_i), .base_idx_i(base_idx_i), .mode_i(mode_i), .wb_i(wb_i),
    .instr_addr_i(instr_addr_i), .rf_idx_o(rf_idx_o), .rf_data_i(rf_data_i),
    .mem_valid_o(mem_valid_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
    .mem_ready_i(mem_ready), .busy_o(busy_o), .done_o(done_o),
    .wb_en_o(wb_en_o), .wb_value_o(wb_value_o)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] exp_addr [16];
  logic [31:0] exp_data [16];
  string       exp_tag  [16];
  int          exp_n;
  logic [31:0] exp_wb;
  logic [31:0] got_addr [32];
  logic [31:0] got_data [32];
  int          got_n;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  // expected writes from the requirements
  task automatic predict(input logic [15:0] mask, input logic [31:0] base,
                         input logic [3:0] bidx, input logic [1:0] mode,
                         input bit wb, input logic [31:0] instr);
    int n;
    int k;
    logic [31:0] fin;
    n = 0;
    for (int i = 0; i < 16; i++) if (mask[i]) n++;
    exp_n = n;
    fin = mode[1] ? base - 32'(4 * n) : base + 32'(4 * n);
    exp_wb = wb ? fin : base;
    k = 0;
    for (int i = 0; i < 16; i++) begin
      if (mask[i]) begin
        case (mode)
          2'b00:   exp_addr[k] = base + 32'(4 * k);
          2'b01:   exp_addr[k] = base + 32'(4 + 4 * k);
          2'b10:   exp_addr[k] = base - 32'(4 * (n - 1 - k));
          default: exp_addr[k] = base - 32'(4 * (n - k));
        endcase
        if (i == 15) begin
          exp_data[k] = instr + 32'd12; exp_tag[k] = "R7";
        end else if (i == int'(bidx)) begin
          exp_data[k] = (k == 0) ? base : (wb ? fin : base);
          exp_tag[k]  = (k == 0) ? "R8" : "R9";
        end else begin
          exp_data[k] = rf[i]; exp_tag[k] = "R1";
        end
        k++;
      end
    end
  endtask

  task automatic tick(input bit rdy_all);
    @(negedge clk);
    mem_ready = rdy_all ? 1'b1 : ($urandom_range(0, 3) != 0);
    if (mem_valid_o && mem_ready) begin
      if (got_n < 32) begin
        got_addr[got_n] = mem_addr_o;
        got_data[got_n] = mem_data_o;
      end
      got_n++;
    end
  endtask

  task automatic run_case(input logic [15:0] mask, input logic [31:0] base,
                          input logic [3:0] bidx, input logic [1:0] mode,
                          input bit wb, input logic [31:0] instr,
                          input bit rdy_all, input bit poke);
    int lat;
    bit seen;
    for (int i = 0; i < 16; i++) rf[i] = $urandom;
    predict(mask, base, bidx, mode, wb, instr);
    got_n = 0;
    tick(rdy_all);
    start_i = 1'b1; reg_mask_i = mask; base_i = base; base_idx_i = bidx;
    mode_i = mode; wb_i = wb; instr_addr_i = instr;
    lat = 0;
    seen = 1'b0;
    while (!seen && lat < 400) begin
      tick(rdy_all);
      lat++;
      if (poke && lat == 1) begin
        start_i = 1'b1; reg_mask_i = ~mask; base_i = base ^ 32'h0000_0ff0;
        mode_i = ~mode; wb_i = ~wb;
      end else begin
        start_i = 1'b0;
      end
      if (done_o) seen = 1'b1;
    end
    check(seen, "R11", "done pulse seen", 32'(seen), 32'd1);
    check(wb_value_o == exp_wb, (mask == 0) ? "R12" : "R6", "writeback value",
          wb_value_o, exp_wb);
    check(wb_en_o == wb, "R6", "writeback enable", 32'(wb_en_o), 32'(wb));
    if (rdy_all && !poke)
      check(lat == ((exp_n == 0) ? 1 : exp_n + 2), "R11", "done latency",
            32'(lat), 32'((exp_n == 0) ? 1 : exp_n + 2));
    check(got_n == exp_n, (mask == 0) ? "R12" : "R11", "write count",
          32'(got_n), 32'(exp_n));
    for (int k = 0; k < exp_n && k < got_n; k++) begin
      check(got_addr[k] == exp_addr[k], mode_tag(mode), "write address",
            got_addr[k], exp_addr[k]);
      check(got_data[k] == exp_data[k], exp_tag[k], "write data",
            got_data[k], exp_data[k]);
    end
    for (int j = 0; j < 3; j++) tick(1'b1);
    check(got_n == exp_n && !busy_o && !done_o, poke ? "R13" : "R11",
          "idle after done", 32'(got_n), 32'(exp_n));
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 16; i++) rf[i] = '0;
    got_n = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R14
    check(!mem_valid_o && !done_o && !busy_o, "R14", "reset state",
          {29'd0, mem_valid_o, done_o, busy_o}, 32'd0);

    run_case(16'h3fff, 32'h800, 4'd14, 2'b00, 1'b1, 32'h100, 1'b1, 1'b0);
    run_case(16'h3fff, 32'h800, 4'd14, 2'b01, 1'b1, 32'h140, 1'b1, 1'b0);
    run_case(16'h4000, 32'h800, 4'd14, 2'b01, 1'b1, 32'h180, 1'b1, 1'b0);
    run_case(16'hc000, 32'h800, 4'd0,  2'b10, 1'b0, 32'h1c0, 1'b1, 1'b0);
    run_case(16'h0601, 32'h800, 4'd9,  2'b11, 1'b1, 32'h200, 1'b1, 1'b0);
    run_case(16'h0201, 32'h800, 4'd9,  2'b11, 1'b0, 32'h204, 1'b1, 1'b0);
    run_case(16'h0000, 32'h900, 4'd3,  2'b11, 1'b1, 32'h208, 1'b1, 1'b0);
    run_case(16'hffff, 32'h1000, 4'd3, 2'b00, 1'b1, 32'h20c, 1'b0, 1'b0);
    run_case(16'h0003, 32'h400, 4'd0,  2'b10, 1'b1, 32'h210, 1'b1, 1'b0);
    run_case(16'h8421, 32'h600, 4'd5,  2'b01, 1'b1, 32'h214, 1'b1, 1'b1);

    for (int t = 0; t < 40; t++) begin
      logic [15:0] m;
      m = (t % 9 == 0) ? 16'h0000 : 16'($urandom);
      run_case(m, {$urandom_range(16'h100, 16'hff00), 2'b00} , 4'($urandom_range(0, 14)),
               2'($urandom), 1'($urandom), {$urandom_range(0, 32'h3fff_ffff), 2'b00},
               1'($urandom_range(0, 1)), (m != 0) && (t % 7 == 3));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule